// File: doc/BRIEF.md
# Bit-Serial Reflected GF(2^128) Multiplier

This block computes the carryless product of two 128-bit operands and reduces it in a binary field. The reduction polynomial is a programmable 16-bit value given in reflected bit order. Every operand and the result are carried as a pair of 64-bit words, high and low. The block works one bit per clock. It walks the bits of X from the top of its high word down to the bottom of its low word. Meanwhile a copy of Y, called V, shifts right through a 128-bit register. Whenever a one falls off the bottom of V, the polynomial is folded into the top of V.

A host drives the operands and polynomial, then pulses `start_i` while the block is idle. The block captures everything on that edge and is busy for 128 clocks. It then pulses `done_o` for one clock. The result stays on `res_hi_o`/`res_lo_o` until the next accepted start. The reset input is asynchronous and active low; its release is synchronised inside the block.

Top module: `gfm_serial_mul`

## Requirements
- R1: While reset is applied and after it is released, with no start given, `busy_o` and `done_o` are low and the result reads zero.
- R2: The result is the sum of the V values selected by the ones of X, with Z starting at zero and V at Y. X = 0 gives zero. An X whose only one is bit 63 of the high word (examined first) gives exactly Y.
- R3: V shifts right by one per iteration across both words, so that the high word's bit 0 enters the low word's bit 63. With the polynomial zero, X equal to low-word bit 0 (examined last) and Y equal to high-word bit 63, the result is low word 1, high word 0.
- R4: When a one leaves bit 0 of V's low word, the polynomial shifted left by 48 is XORed into V's high word. With X equal to high-word bit 62, Y equal to 1 and polynomial 0x1234, the result is high word 0x1234_0000_0000_0000 and low word 0. General operands match this iteration rule over 128 steps.
- R5: `done_o` rises exactly 128 clocks after the edge on which a start is accepted.
- R6: `busy_o` is high from the clock after an accepted start until the clock in which `done_o` is high. `busy_o` is low together with `done_o`.
- R7: A start strobe seen while `busy_o` is high is ignored: the running multiply finishes with its own operands and its own timing.
- R8: X, Y and the polynomial are captured on the accepted start edge. Changing them during the operation does not change the result.
- R9: `done_o` is high for exactly one clock. The result is held unchanged from that clock until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| x_hi_i | input | 64 | Operand X, high word |
| x_lo_i | input | 64 | Operand X, low word |
| y_hi_i | input | 64 | Operand Y, high word |
| y_lo_i | input | 64 | Operand Y, low word |
| poly_i | input | 16 | Reflected reduction polynomial |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-clock completion pulse |
| res_hi_o | output | 64 | Result, high word |
| res_lo_o | output | 64 | Result, low word |

## Verification
An all-zero X and an X whose only one is the first-examined bit tell apart an accumulator that starts at zero from one that does not. They also show whether the sum is taken before V moves. A single one at the last-examined X bit, with the polynomial zero, pushes one Y bit through 127 shifts. Only a correct carry from the high word into the low word lands it at bit 0. A second-bit X against Y = 1 makes the result equal the folded polynomial itself, which exposes a wrong fold position or a missing fold. Dense mixed operands with several polynomials are compared against the iteration rule. Runs that restart or change inputs in mid-operation separate true operand capture from live sampling.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  // Controller phases of the bit-serial multiply.
  typedef enum logic [0:0] {
    GFM_IDLE = 1'b0,
    GFM_RUN  = 1'b1
  } gfm_phase_e;

endpackage

// File: rtl/gfm_rst_sync.sv
// Asserts asynchronously, releases on the clock after STAGES edges.
module gfm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/gfm_ctrl.sv
// Sequencer: accepts a start when idle, issues ITERS step enables,
// then a single-cycle done.
module gfm_ctrl
  import gfm_pkg::*;
#(
  parameter int ITERS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITERS - 1);

  gfm_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;
  logic             last_step;

  assign load_o    = (phase_q == GFM_IDLE) && start_i;
  assign step_o    = (phase_q == GFM_RUN);
  assign last_step = step_o && (cnt_q == LAST_CNT);
  assign cnt_en    = load_o || step_o;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load_o) begin
      phase_d = GFM_RUN;
      cnt_d   = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last_step) begin
        phase_d = GFM_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= GFM_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = step_o;
  assign done_o = done_q;

endmodule

// File: rtl/gfm_vreg.sv
// Shifting multiplicand V with the reflected polynomial fold.
module gfm_vreg #(
  parameter int WIDE_W = 128,
  parameter int POLY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WIDE_W-1:0] y_i,
  input  logic [POLY_W-1:0] poly_i,
  output logic [WIDE_W-1:0] v_o
);

  localparam int FOLD_LSB = WIDE_W - POLY_W;

  logic [WIDE_W-1:0] v_q, v_d, v_shift;
  logic [POLY_W-1:0] poly_q;
  logic              v_en;

  assign v_en = load_i || step_i;

  // Right shift across the word pair; a zero enters the top.
  always_comb begin
    v_shift = {1'b0, v_q[WIDE_W-1:1]};
    if (v_q[0]) begin
      v_shift[WIDE_W-1:FOLD_LSB] = v_shift[WIDE_W-1:FOLD_LSB] ^ poly_q;
    end
  end

  always_comb begin
    if (load_i) begin
      v_d = y_i;
    end else begin
      v_d = v_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (v_en) begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= '0;
    end else if (load_i) begin
      poly_q <= poly_i;
    end
  end

  assign v_o = v_q;

endmodule

// File: rtl/gfm_zacc.sv
// Multiplier-bit shifter and accumulator Z.
module gfm_zacc #(
  parameter int WIDE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WIDE_W-1:0] x_i,
  input  logic [WIDE_W-1:0] v_i,
  output logic [WIDE_W-1:0] z_o
);

  logic [WIDE_W-1:0] x_q, x_d;
  logic [WIDE_W-1:0] z_q, z_d;
  logic              sel_bit;
  logic              reg_en;

  assign reg_en  = load_i || step_i;
  assign sel_bit = x_q[WIDE_W-1];

  always_comb begin
    if (load_i) begin
      x_d = x_i;
      z_d = '0;
    end else begin
      x_d = {x_q[WIDE_W-2:0], 1'b0};
      z_d = sel_bit ? (z_q ^ v_i) : z_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      z_q <= '0;
    end else if (reg_en) begin
      x_q <= x_d;
      z_q <= z_d;
    end
  end

  assign z_o = z_q;

endmodule

// File: rtl/gfm_serial_mul.sv
module gfm_serial_mul #(
  parameter int WORD_W = 64,
  parameter int POLY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] x_hi_i,
  input  logic [WORD_W-1:0] x_lo_i,
  input  logic [WORD_W-1:0] y_hi_i,
  input  logic [WORD_W-1:0] y_lo_i,
  input  logic [POLY_W-1:0] poly_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] res_hi_o,
  output logic [WORD_W-1:0] res_lo_o
);

  localparam int WIDE_W = 2 * WORD_W;
  localparam int ITERS  = WIDE_W;

  logic              rst_n_s;
  logic              load;
  logic              step;
  logic [WIDE_W-1:0] v_cur;
  logic [WIDE_W-1:0] z_cur;

  gfm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_s)
  );

  gfm_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  gfm_vreg #(.WIDE_W(WIDE_W), .POLY_W(POLY_W)) u_vreg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load),
    .step_i (step),
    .y_i    ({y_hi_i, y_lo_i}),
    .poly_i (poly_i),
    .v_o    (v_cur)
  );

  gfm_zacc #(.WIDE_W(WIDE_W)) u_zacc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load),
    .step_i (step),
    .x_i    ({x_hi_i, x_lo_i}),
    .v_i    (v_cur),
    .z_o    (z_cur)
  );

  assign res_hi_o = z_cur[WIDE_W-1:WORD_W];
  assign res_lo_o = z_cur[WORD_W-1:0];

endmodule

// File: rtl/gfm_serial_mul_chk.sv
module gfm_serial_mul_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] res_hi_o,
  input logic [WORD_W-1:0] res_lo_o
);

  localparam int ITERS = 2 * WORD_W;
  localparam int RUN_W = $clog2(ITERS + 1) + 1;

  logic [RUN_W-1:0] run_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q <= '0;
    end else if (busy_o) begin
      run_len_q <= run_len_q + 1'b1;
    end else begin
      run_len_q <= '0;
    end
  end

  // R9: completion is a single-clock pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: result unchanged while idle
  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> ($stable(res_hi_o) && $stable(res_lo_o)));

  // R6: busy low in the done cycle, and busy only ends with done
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r6_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R5: done after exactly ITERS busy cycles
  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len_q == RUN_W'(ITERS)));

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_len_q < RUN_W'(ITERS)));

  // R7: a start while busy does not end the run early
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && run_len_q < RUN_W'(ITERS - 1)) |=> busy_o);

endmodule

bind gfm_serial_mul gfm_serial_mul_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .res_hi_o (res_hi_o),
  .res_lo_o (res_lo_o)
);

// File: tb/gfm_serial_mul_bench.sv
module gfm_serial_mul_bench;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] x_hi_i, x_lo_i, y_hi_i, y_lo_i;
  logic [15:0] poly_i;
  logic        busy_o, done_o;
  logic [63:0] res_hi_o, res_lo_o;

  int errors = 0;
  int checks = 0;

  gfm_serial_mul u_gfm_serial_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .x_hi_i   (x_hi_i),
    .x_lo_i   (x_lo_i),
    .y_hi_i   (y_hi_i),
    .y_lo_i   (y_lo_i),
    .poly_i   (poly_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .res_hi_o (res_hi_o),
    .res_lo_o (res_lo_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Iteration rule from the requirements (R2, R3, R4).
  function automatic logic [127:0] expect_mul(input logic [127:0] x,
                                              input logic [127:0] y,
                                              input logic [15:0] p);
    logic [127:0] z;
    logic [127:0] v;
    logic         out_bit;
    z = '0;
    v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z = z ^ v;
      out_bit = v[0];
      v = v >> 1;
      if (out_bit) v[127:112] = v[127:112] ^ p;
    end
    return z;
  endfunction

  // mode 0: plain; 1: restart attempt mid-run; 2: inputs changed mid-run
  task automatic run_op(input logic [127:0] x, input logic [127:0] y,
                        input logic [15:0] p, input int mode,
                        output logic [127:0] res);
    bit ok_busy;
    @(negedge clk);
    {x_hi_i, x_lo_i} = x;
    {y_hi_i, y_lo_i} = y;
    poly_i  = p;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R6 busy after start",
        {126'd0, busy_o, done_o}, 128'd2);
    ok_busy = 1'b1;
    for (int k = 1; k < 128; k++) begin
      if (k == 40 && mode != 0) begin
        {x_hi_i, x_lo_i} = ~x;
        {y_hi_i, y_lo_i} = {y[63:0], y[127:64]} ^ 128'h5a5a;
        poly_i = p ^ 16'hffff;
        if (mode == 1) start_i = 1'b1;
      end
      if (k == 41) start_i = 1'b0;
      @(negedge clk);
      if (busy_o !== 1'b1 || done_o !== 1'b0) ok_busy = 1'b0;
    end
    chk(ok_busy, "R5/R6/R7 busy held, no early done", {127'd0, ok_busy}, 128'd1);
    @(negedge clk);
    chk(done_o === 1'b1 && busy_o === 1'b0, "R5/R6 done at 128 clocks",
        {126'd0, busy_o, done_o}, 128'd1);
    res = {res_hi_o, res_lo_o};
    @(negedge clk);
    chk(done_o === 1'b0, "R9 done one clock", {127'd0, done_o}, 128'd0);
    repeat (3) @(negedge clk);
    chk({res_hi_o, res_lo_o} === res, "R9 result held", {res_hi_o, res_lo_o}, res);
  endtask

  task automatic t_reset();
    start_i = 1'b0;
    {x_hi_i, x_lo_i, y_hi_i, y_lo_i} = '0;
    poly_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
        {126'd0, busy_o, done_o}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && {res_hi_o, res_lo_o} === 128'd0,
        "R1 after release", {res_hi_o, res_lo_o}, 128'd0);
  endtask

  task automatic t_r2_basic();
    logic [127:0] r;
    logic [127:0] y;
    y = 128'hdead_beef_0123_4567_89ab_cdef_f0e1_d2c3;
    run_op(128'd0, y, 16'he100, 0, r);
    chk(r === 128'd0, "R2 X zero", r, 128'd0);
    run_op(128'd1 << 127, y, 16'he100, 0, r);
    chk(r === y, "R2 first X bit gives Y", r, y);
  endtask

  task automatic t_r3_cross();
    logic [127:0] r;
    run_op(128'd1, 128'd1 << 127, 16'h0000, 0, r);
    chk(r === 128'd1, "R3 shift across words", r, 128'd1);
  endtask

  task automatic t_r4_fold();
    logic [127:0] r;
    logic [127:0] e;
    logic [127:0] x;
    logic [127:0] y;
    run_op(128'd1 << 126, 128'd1, 16'h1234, 0, r);
    chk(r === {16'h1234, 112'd0}, "R4 fold position", r, {16'h1234, 112'd0});
    for (int n = 0; n < 3; n++) begin
      x = {64'h0f1e_2d3c_4b5a_6978 ^ (64'd1 << (n * 7)), 64'h8796_a5b4_c3d2_e1f0 + 64'(n)};
      y = {64'hfeed_face_cafe_babe, 64'h1357_9bdf_2468_ace1 ^ 64'(n * 3)};
      e = expect_mul(x, y, 16'he100 >> n);
      run_op(x, y, 16'he100 >> n, 0, r);
      chk(r === e, "R4 general product", r, e);
    end
  endtask

  task automatic t_r7_restart();
    logic [127:0] r;
    logic [127:0] x;
    logic [127:0] y;
    logic [127:0] e;
    x = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3211;
    y = 128'h1111_2222_3333_4444_5555_6666_7777_8889;
    e = expect_mul(x, y, 16'h8701);
    run_op(x, y, 16'h8701, 1, r);
    chk(r === e, "R7 start while busy ignored", r, e);
  endtask

  task automatic t_r8_capture();
    logic [127:0] r;
    logic [127:0] x;
    logic [127:0] y;
    logic [127:0] e;
    x = 128'hffff_0000_aaaa_5555_0f0f_f0f0_3c3c_c3c3;
    y = 128'h8000_0000_0000_0001_0000_0000_0000_0003;
    e = expect_mul(x, y, 16'hc200);
    run_op(x, y, 16'hc200, 2, r);
    chk(r === e, "R8 inputs captured at start", r, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_r2_basic();
    t_r3_cross();
    t_r4_fold();
    t_r7_restart();
    t_r8_capture();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule